// File: doc/BRIEF.md
# Multi-phase quad SPI master

This block is an SPI master with one active-low chip select, a serial clock and four bidirectional data lines. A transfer is a short chain of phase descriptors held in a small table. Each descriptor selects a bus width (single-wire half duplex, full duplex, dual or quad), a direction (transmit, receive, both, or a dummy phase that only clocks) and a byte count. All phases of one transfer run inside a single chip-select assertion. The bus width, direction and byte count change at each phase boundary without a gap in the clock.

Register-style writes load the descriptor table and push transmit bytes into a small queue. A start pulse runs the chain from entry 0. Each received byte appears for one cycle on a byte-wide receive port. A manual path sends one byte at a time from input fields, without the table. While a manual byte is not marked final, the chip select stays low between bytes.

Top module: `qspi_phase_master`

## Requirements
- R1: After reset cs_n is 1, sck is 0, io_oe is 0000, and busy, hold, done and rx_valid are 0.
- R2: sck idles low. Its period is 2*(div+1) system clocks. The first rising edge comes (div+1) clocks after cs_n falls. io_out changes only at falling edges, and inputs are sampled at rising edges (mode 0).
- R3: Width code 0 (half duplex) uses IO0 only. A transmitting phase drives IO0 with io_oe=0001. A receive-only phase samples IO0 with io_oe=0000.
- R4: Width code 1 (full duplex) moves one bit per clock. Transmit data leaves on IO0. When the phase receives, a bit is captured from IO1 on the same clock.
- R5: Width code 2 (dual) moves two bits per clock on IO1:IO0, and width code 3 (quad) moves four bits per clock on IO3:IO0. Data goes MSB first, and the highest lane carries the most significant bit of each group.
- R6: Direction bit 0 means transmit and bit 1 means receive. The value 11 captures only in full duplex and acts as transmit-only at the other widths. The value 00 is a dummy phase: it clocks the programmed number of bytes, drives no lane and returns no bytes.
- R7: A count field value n gives n+1 bytes in the phase. Each received byte produces exactly one one-cycle rx_valid pulse with the byte on rx_byte.
- R8: A transfer runs the descriptors from index 0 upward inside one cs_n low period. It ends after the descriptor whose last flag is set, or after the final table entry.
- R9: Transmit bytes are taken from the queue in push order. A transmit byte needed while the queue is empty is sent as 00h.
- R10: busy is high from the accepted start until cs_n returns high. done is a one-cycle pulse in the cycle cs_n rises. A start pulse while busy is ignored.
- R11: man_go, accepted when idle or held, sends one byte with the given width and direction. With man_last=0 the block then holds: cs_n stays low, sck stays low, and hold and busy are 1 until the next man_go. With man_last=1 it releases cs_n.
- R12: io_oe is nonzero only while a transmitting phase is clocking. It then enables exactly that phase's lanes. It is 0000 in receive-only and dummy phases, in the hold state and in the tail before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | DIV_W | Clock divider; sck = clk / (2*(div+1)) |
| desc_we | input | 1 | Write one descriptor table entry |
| desc_sel | input | SEL_W | Table entry index to write |
| desc_width | input | 2 | Width code: 0 half, 1 full, 2 dual, 3 quad |
| desc_dir | input | 2 | Direction: bit0 transmit, bit1 receive |
| desc_len | input | CNT_W | Byte count minus one |
| desc_last | input | 1 | Final-phase flag |
| tx_we | input | 1 | Push tx_byte into the transmit queue |
| tx_byte | input | 8 | Transmit byte |
| start | input | 1 | Run the descriptor chain |
| man_go | input | 1 | Send one manual byte |
| man_width | input | 2 | Width code for the manual byte |
| man_dir | input | 2 | Direction for the manual byte |
| man_last | input | 1 | Release chip select after the manual byte |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Per-line output enables |
| io_in | input | 4 | Data line input values |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| hold | output | 1 | Waiting for the next manual byte with chip select low |
| done | output | 1 | One-cycle pulse at chip-select release |

## Verification
The hardest situations to reach are the phase boundaries. There, the byte that just finished was shifted at one width, and the next byte must be loaded and driven at another width and direction on the very same falling edge. The bench chains mixed-width descriptors, including a dummy phase and a receive tail. It decodes every sampled rising edge against an arithmetically generated slave pattern, so that a lane or group off by one shows up in the decoded bytes. A second hard situation is the hold state between manual bytes. The bench reaches it by issuing a non-final manual byte, letting it idle, and then finishing with a byte of a different width and direction.

// File: rtl/qspi_pm_pkg.sv
package qspi_pm_pkg;

  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    W_HALF = 2'd0,
    W_FULL = 2'd1,
    W_DUAL = 2'd2,
    W_QUAD = 2'd3
  } width_e;

  typedef struct packed {
    logic             last;
    logic [1:0]       dir;
    width_e           width;
    logic [CNT_W-1:0] nbytes_m1;
  } desc_t;

  // Rising edges needed for one byte at a given width.
  function automatic logic [3:0] groups_of(width_e w);
    case (w)
      W_DUAL:  return 4'd4;
      W_QUAD:  return 4'd2;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(width_e w);
    case (w)
      W_DUAL:  return 4'b0011;
      W_QUAD:  return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  // Capture happens in full duplex whenever the receive bit is set,
  // otherwise only in a receive-only phase.
  function automatic logic rx_enabled(width_e w, logic [1:0] d);
    return d[1] & ((w == W_FULL) | ~d[0]);
  endfunction

endpackage

// File: rtl/qspi_pm_clkgen.sv
module qspi_pm_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             toggle,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             tick,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);
  assign rise = tick && toggle && !sck;
  assign fall = tick && toggle && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      sck <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick && toggle) sck <= ~sck;
    end
  end

endmodule

// File: rtl/qspi_pm_txq.sv
module qspi_pm_txq #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] din,
  input  logic       pop,
  output logic [7:0] head,
  output logic       empty
);

  logic [7:0]  mem [DEPTH];
  logic [AW:0] wp, rp;
  logic        full;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign head  = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

endmodule

// File: rtl/qspi_pm_shifter.sv
module qspi_pm_shifter
  import qspi_pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  width_e     width,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift,
  input  logic       sample,
  input  logic [3:0] io_in,
  output logic [3:0] lanes_out,
  output logic [7:0] rx_next
);

  logic [7:0] tx_sr, rx_sr;

  always_comb begin
    case (width)
      W_HALF:  rx_next = {rx_sr[6:0], io_in[0]};
      W_FULL:  rx_next = {rx_sr[6:0], io_in[1]};
      W_DUAL:  rx_next = {rx_sr[5:0], io_in[1:0]};
      default: rx_next = {rx_sr[3:0], io_in};
    endcase
  end

  always_comb begin
    case (width)
      W_DUAL:  lanes_out = {2'b00, tx_sr[7:6]};
      W_QUAD:  lanes_out = tx_sr[7:4];
      default: lanes_out = {3'b000, tx_sr[7]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else begin
      if (load) begin
        tx_sr <= load_byte;
      end else if (shift) begin
        case (width)
          W_DUAL:  tx_sr <= {tx_sr[5:0], 2'b00};
          W_QUAD:  tx_sr <= {tx_sr[3:0], 4'b0000};
          default: tx_sr <= {tx_sr[6:0], 1'b0};
        endcase
      end
      if (sample) rx_sr <= rx_next;
    end
  end

endmodule

// File: rtl/qspi_phase_master.sv
module qspi_phase_master
  import qspi_pm_pkg::*;
#(
  parameter int NDESC     = 4,
  parameter int DIV_W     = 4,
  parameter int TXQ_DEPTH = 16,
  localparam int SEL_W    = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             desc_we,
  input  logic [SEL_W-1:0] desc_sel,
  input  logic [1:0]       desc_width,
  input  logic [1:0]       desc_dir,
  input  logic [CNT_W-1:0] desc_len,
  input  logic             desc_last,
  input  logic             tx_we,
  input  logic [7:0]       tx_byte,
  input  logic             start,
  input  logic             man_go,
  input  logic [1:0]       man_width,
  input  logic [1:0]       man_dir,
  input  logic             man_last,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in,
  output logic             rx_valid,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             hold,
  output logic             done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PAUSE, S_TAIL} state_e;

  state_e           state;
  desc_t            tbl [NDESC];
  desc_t            cur, ld_desc, man_desc;
  logic [SEL_W-1:0] didx;
  logic [CNT_W-1:0] bcnt;
  logic [2:0]       gcnt;
  logic             man;

  logic tick, rise, fall;
  logic q_empty;
  logic [7:0] q_head, rx_next, ld_byte;
  logic [3:0] lanes_out;

  // Named events, also observed by the checker.
  logic go_start, go_man, last_grp, more_bytes, more_desc;
  logic byte_end, next_byte, next_desc, seq_end;
  logic ld, pop, shift, sample;

  assign man_desc   = '{last: man_last, dir: man_dir, width: width_e'(man_width),
                        nbytes_m1: '0};
  assign go_start   = (state == S_IDLE) && start;
  assign go_man     = ((state == S_IDLE) || (state == S_PAUSE)) && man_go && !go_start;
  assign last_grp   = ({1'b0, gcnt} == (groups_of(cur.width) - 4'd1));
  assign more_bytes = (bcnt != '0);
  assign more_desc  = !man && !cur.last && (didx != SEL_W'(NDESC - 1));
  assign byte_end   = (state == S_RUN) && fall && last_grp;
  assign next_byte  = byte_end && more_bytes;
  assign next_desc  = byte_end && !more_bytes && more_desc;
  assign seq_end    = byte_end && !more_bytes && !more_desc;
  assign shift      = (state == S_RUN) && fall && !last_grp;
  assign sample     = (state == S_RUN) && rise;

  always_comb begin
    if (go_start)       ld_desc = tbl[0];
    else if (go_man)    ld_desc = man_desc;
    else if (next_desc) ld_desc = tbl[didx + SEL_W'(1)];
    else                ld_desc = cur;
  end

  assign ld      = go_start || go_man || next_byte || next_desc;
  assign pop     = ld && ld_desc.dir[0] && !q_empty;
  assign ld_byte = pop ? q_head : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) tbl[i] <= '0;
    end else if (desc_we) begin
      tbl[desc_sel] <= '{last: desc_last, dir: desc_dir, width: width_e'(desc_width),
                         nbytes_m1: desc_len};
    end
  end

  qspi_pm_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     ((state == S_RUN) || (state == S_TAIL)),
    .toggle (state == S_RUN),
    .div    (div),
    .sck    (sck),
    .tick   (tick),
    .rise   (rise),
    .fall   (fall)
  );

  qspi_pm_txq #(.DEPTH(TXQ_DEPTH)) txq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_we),
    .din   (tx_byte),
    .pop   (pop),
    .head  (q_head),
    .empty (q_empty)
  );

  qspi_pm_shifter shifter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .width     (cur.width),
    .load      (ld),
    .load_byte (ld_byte),
    .shift     (shift),
    .sample    (sample),
    .io_in     (io_in),
    .lanes_out (lanes_out),
    .rx_next   (rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur      <= '0;
      didx     <= '0;
      bcnt     <= '0;
      gcnt     <= '0;
      man      <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      case (state)
        S_IDLE, S_PAUSE: begin
          if (go_start || go_man) begin
            state <= S_RUN;
            cs_n  <= 1'b0;
            cur   <= ld_desc;
            didx  <= '0;
            bcnt  <= ld_desc.nbytes_m1;
            gcnt  <= '0;
            man   <= go_man;
          end
        end
        S_RUN: begin
          if (sample && last_grp && rx_enabled(cur.width, cur.dir)) begin
            rx_valid <= 1'b1;
            rx_byte  <= rx_next;
          end
          if (fall) gcnt <= last_grp ? '0 : gcnt + 1'b1;
          if (next_byte) bcnt <= bcnt - 1'b1;
          if (next_desc) begin
            cur  <= ld_desc;
            didx <= didx + 1'b1;
            bcnt <= ld_desc.nbytes_m1;
          end
          if (seq_end) state <= (man && !cur.last) ? S_PAUSE : S_TAIL;
        end
        default: begin
          if (tick) begin
            state <= S_IDLE;
            cs_n  <= 1'b1;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign io_out = lanes_out;
  assign io_oe  = ((state == S_RUN) && cur.dir[0]) ? lane_mask(cur.width) : 4'b0000;
  assign busy   = (state != S_IDLE);
  assign hold   = (state == S_PAUSE);

endmodule

// File: rtl/qspi_pm_chk.sv
module qspi_pm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       busy,
  input logic       hold,
  input logic       done,
  input logic       rx_valid,
  input logic       byte_end,
  input logic       seq_end
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck && io_oe == 4'b0000));

  a_r2_sck_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r2_out_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(io_out));

  a_r7_rx_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n);

  a_r8_cs_held_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> !cs_n);

  a_r8_end_enters_tail_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> (!sck && io_oe == 4'b0000));

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy && $past(!cs_n)));

  a_r11_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (busy && !cs_n && !sck && io_oe == 4'b0000));

  a_r12_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

endmodule

bind qspi_phase_master qspi_pm_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sck      (sck),
  .cs_n     (cs_n),
  .io_out   (io_out),
  .io_oe    (io_oe),
  .busy     (busy),
  .hold     (hold),
  .done     (done),
  .rx_valid (rx_valid),
  .byte_end (byte_end),
  .seq_end  (seq_end)
);

// File: tb/qspi_phase_master_tb_top.sv
module qspi_phase_master_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div = 4'd1;
  logic       desc_we = 1'b0;
  logic [1:0] desc_sel = '0;
  logic [1:0] desc_width = '0, desc_dir = '0;
  logic [3:0] desc_len = '0;
  logic       desc_last = 1'b0;
  logic       tx_we = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       start = 1'b0, man_go = 1'b0, man_last = 1'b0;
  logic [1:0] man_width = '0, man_dir = '0;
  logic       sck, cs_n, rx_valid, busy, hold, done;
  logic [3:0] io_out, io_oe, io_in;
  logic [7:0] rx_byte;

  always #4 clk = ~clk;

  qspi_phase_master dut_i (.*);

  int checks = 0, fails = 0;
  int nr = 0, nf = 0, nrx = 0, ndone = 0, ncsr = 0, txk = 0;
  logic [3:0] m_out [512];
  logic [3:0] m_oe  [512];
  logic [7:0] rxb   [64];
  realtime tr0, tr1, tcsf;
  int pw [4], pd [4], pn [4], pl [4];

  function automatic logic [3:0] pat(int k);
    return 4'((k * 5 + 3) ^ (k >> 1));
  endfunction
  function automatic logic [7:0] txv(int k);
    return 8'(k * 29 + 7);
  endfunction
  function automatic int lanes(int w);
    return (w == 3) ? 4 : (w == 2) ? 2 : 1;
  endfunction
  function automatic logic [3:0] lbits(logic [3:0] v, int w, bit rxs);
    if (w == 3) return v;
    if (w == 2) return {2'b00, v[1:0]};
    if (w == 1 && rxs) return {3'b000, v[1]};
    return {3'b000, v[0]};
  endfunction
  function automatic string wtag(int w);
    return (w == 0) ? "R3" : (w == 1) ? "R4" : "R5";
  endfunction

  assign io_in = pat(nf);
  always @(negedge sck) nf++;
  always @(posedge sck) begin
    if (nr < 512) begin m_out[nr] = io_out; m_oe[nr] = io_oe; end
    if (nr == 0) tr0 = $realtime;
    if (nr == 1) tr1 = $realtime;
    nr++;
  end
  always @(negedge cs_n) tcsf = $realtime;
  always @(posedge cs_n) ncsr++;
  always @(negedge clk) begin
    if (rx_valid) begin if (nrx < 64) rxb[nrx] = rx_byte; nrx++; end
    if (done) ndone++;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    nr = 0; nf = 0; nrx = 0; ndone = 0; ncsr = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (ndone == 0 && t < 20000) begin @(negedge clk); t++; end
    if (ndone == 0) chk(0, "R10", "done timeout", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(int dv, bit push_tx, bit restart);
    int np, r, tk, rk, ntx, e_rise, e_rx;
    logic [7:0] tb, rb;
    bit oe_ok;
    div = 4'(dv);
    np = 0;
    for (int p = 0; p < 4; p++) begin np = p + 1; if (pl[p] != 0) break; end
    ntx = 0; e_rise = 0; e_rx = 0;
    for (int p = 0; p < np; p++) begin
      if (pd[p] % 2 == 1) ntx += pn[p] + 1;
      e_rise += (pn[p] + 1) * 8 / lanes(pw[p]);
      if (pd[p] >= 2 && (pw[p] == 1 || pd[p] == 2)) e_rx += pn[p] + 1;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      desc_we = 1; desc_sel = 2'(i); desc_width = 2'(pw[i]); desc_dir = 2'(pd[i]);
      desc_len = 4'(pn[i]); desc_last = pl[i][0];
    end
    @(negedge clk) desc_we = 0;
    if (push_tx) for (int i = 0; i < ntx; i++) begin
      @(negedge clk) tx_we = 1; tx_byte = txv(txk + i);
    end
    @(negedge clk) tx_we = 0;
    clear_mon();
    start = 1; @(negedge clk) start = 0;
    if (restart) begin
      repeat (6) @(negedge clk);
      chk(busy == 1, "R10", "busy mid-transfer", busy, 1);
      start = 1; @(negedge clk) start = 0;
    end
    wait_done();
    chk(tr1 - tr0 == 16.0 * (dv + 1), "R2", "sck period ns", int'(tr1 - tr0), 16 * (dv + 1));
    chk(tr0 - tcsf == 8.0 * (dv + 1), "R2", "cs-to-first-rise ns", int'(tr0 - tcsf), 8 * (dv + 1));
    r = 0; tk = 0; rk = 0;
    for (int p = 0; p < np; p++) begin
      oe_ok = 1;
      for (int b = 0; b <= pn[p]; b++) begin
        tb = 0; rb = 0;
        for (int g = 0; g < 8 / lanes(pw[p]); g++) begin
          tb = 8'((tb << lanes(pw[p])) | lbits(m_out[r], pw[p], 0));
          rb = 8'((rb << lanes(pw[p])) | lbits(pat(r), pw[p], 1));
          if (m_oe[r] != ((pd[p] % 2 == 1) ? 4'((1 << lanes(pw[p])) - 1) : 4'd0)) oe_ok = 0;
          r++;
        end
        if (pd[p] % 2 == 1) begin
          chk(tb == (push_tx ? txv(txk + tk) : 8'h00), push_tx ? wtag(pw[p]) : "R9",
              "tx byte", tb, push_tx ? txv(txk + tk) : 0);
          tk++;
        end
        if (pd[p] >= 2 && (pw[p] == 1 || pd[p] == 2)) begin
          chk(rxb[rk] == rb, wtag(pw[p]), "rx byte", rxb[rk], rb);
          rk++;
        end
      end
      chk(oe_ok, "R12", "lane enables in phase", p, p);
    end
    if (push_tx) txk += ntx;
    chk(nr == e_rise, "R7", "rising edges", nr, e_rise);
    chk(nrx == e_rx, "R6", "rx byte count", nrx, e_rx);
    chk(ncsr == 1, "R8", "cs releases", ncsr, 1);
    chk(ndone == 1, "R10", "done pulses", ndone, 1);
    chk(busy == 0 && cs_n == 1, "R10", "idle after done", busy, 0);
  endtask

  task automatic man_byte(int w, int d, bit lst);
    @(negedge clk);
    man_width = 2'(w); man_dir = 2'(d); man_last = lst; man_go = 1;
    @(negedge clk) man_go = 0;
  endtask

  task automatic manual_test();
    int t;
    logic [7:0] tb, rb;
    div = 4'd0;
    @(negedge clk) tx_we = 1; tx_byte = 8'hC3;
    @(negedge clk) tx_we = 0;
    clear_mon();
    man_byte(3, 1, 0);
    t = 0;
    while (!hold && t < 2000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    chk(hold && busy && !cs_n && !sck, "R11", "held between bytes", {hold, busy, cs_n}, 3'b110);
    man_byte(0, 2, 1);
    wait_done();
    tb = {m_out[0], m_out[1]};
    chk(tb == 8'hC3, "R11", "manual quad tx", tb, 8'hC3);
    rb = 0;
    for (int r = 2; r < 10; r++) rb = 8'((rb << 1) | pat(r)[0]);
    chk(nrx == 1 && rxb[0] == rb, "R11", "manual half rx", rxb[0], rb);
    chk(m_oe[5] == 4'd0 && m_oe[0] == 4'hF, "R12", "manual lane enables", m_oe[5], 0);
    chk(nr == 10 && ncsr == 1 && ndone == 1, "R11", "manual edges and release", nr, 10);
  endtask

  task automatic set_ph(int p, int w, int d, int n, int l);
    pw[p] = w; pd[p] = d; pn[p] = n; pl[p] = l;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sck == 0 && io_oe == 0, "R1", "pins in reset", {cs_n, sck, io_oe}, 6'b100000);
    chk(busy == 0 && hold == 0 && done == 0 && rx_valid == 0, "R1", "flags in reset",
        {busy, hold, done, rx_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R3 R4 R5 R6: every width against every direction code
    for (int w = 0; w < 4; w++)
      for (int d = 0; d < 4; d++) begin
        set_ph(0, w, d, 1, 1);
        for (int p = 1; p < 4; p++) set_ph(p, 0, 1, 0, 0);
        run(1, 1, 0);
      end
    // R8: mixed chain ending on flagged entry, with ignored restart (R10)
    set_ph(0, 1, 1, 0, 0); set_ph(1, 3, 1, 2, 0); set_ph(2, 2, 0, 0, 0); set_ph(3, 3, 2, 1, 1);
    run(2, 1, 1);
    // R8: table end without a last flag
    set_ph(0, 0, 1, 0, 0); set_ph(1, 1, 3, 0, 0); set_ph(2, 2, 2, 0, 0); set_ph(3, 3, 3, 0, 0);
    run(0, 1, 0);
    // R8: flag on entry 0 stops the chain early
    set_ph(0, 2, 1, 2, 1); set_ph(1, 3, 1, 3, 0);
    run(3, 1, 0);
    // R9: empty queue sends zero
    set_ph(0, 3, 1, 1, 1);
    run(0, 0, 0);
    manual_test();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule